// File: doc/BRIEF.md
# Transmit Command Outcome Controller

This block decides what happens to a queued transmit command after each transmit attempt. A command's per-command controls are latched when it is loaded. These controls are a retry limit, whether a response frame is expected, and how bandwidth shortfalls, drops and requeues are handled. Each later attempt result then produces exactly one action: finish the command, retry it after a fresh backoff, drop it, hold the queue, or chain the next command after a short or point-coordination interframe space.

The block also keeps a burst flag that records whether the command was entered through a chained start. A drop can be turned into a queue hold in two ways. Inside a burst, a per-command hold bit converts it. Outside a burst, a separate stall bit does. A bandwidth shortfall is handled either by dropping the command or by a quiet retry that leaves the try count untouched. Channel access timing belongs to the surrounding scheduler.

Top module: `txcmd_outcome_ctrl`

## Requirements
- R1: After reset, act_valid, try_count and chain_pifs are all 0 and no command is active.
- R2: cmd_load latches the command controls, clears try_count to 0 in the next cycle and makes the command active. An attempt result given while no command is active, or in the same cycle as cmd_load, produces no action.
- R3: For each accepted attempt, act_valid is high for exactly the one cycle after the att_valid strobe. act_code is 0 finish, 1 retry-after-backoff, 2 drop, 3 hold queue, 4 chain. The result bits are evaluated in a fixed priority: a checked bandwidth shortfall first, then requeue, then success, then failure.
- R4: A successful attempt gives code 0, unless cmd_chain_next is set. In that case it gives code 4, and chain_pifs shows cmd_chain_pifs (0 short space, 1 point-coordination space). chain_pifs is 0 whenever no code 4 is presented.
- R5: A failed attempt (att_success 0) with a response expected increments try_count. The command is retried with code 1 while the new count is below the limit; otherwise the drop rule applies. A limit of 0 allows a single attempt.
- R6: A failed attempt with no response expected finishes the command with code 0 and leaves try_count unchanged, whatever the limit.
- R7: A bandwidth shortfall with the check enabled and cmd_drop_on_bw_short clear gives code 1 and leaves try_count unchanged.
- R8: A bandwidth shortfall with the check enabled and cmd_drop_on_bw_short set applies the drop rule.
- R9: A command is inside a burst when the previous action was code 4. Under the drop rule, such a command gives code 3 if cmd_hold_on_drop_in_burst is set and code 2 otherwise, ignoring cmd_hold_on_drop_solo.
- R10: Under the drop rule, a command outside a burst gives code 3 if cmd_hold_on_drop_solo is set and code 2 otherwise.
- R11: A requeue result gives code 3 when cmd_requeue_as_hold is set. Otherwise it gives code 1 with try_count unchanged.
- R12: With cmd_bw_check_en clear, att_bw_short has no effect, and the attempt is judged by its other result bits.
- R13: Any action other than code 1 ends the command. Further attempt results are ignored until the next cmd_load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_load | input | 1 | Load a new command's controls |
| cmd_retry_limit | input | CNT_W | Allowed attempts (0 means one) |
| cmd_resp_expected | input | 1 | A response frame is expected |
| cmd_bw_check_en | input | 1 | Enable bandwidth shortfall handling |
| cmd_drop_on_bw_short | input | 1 | Drop instead of quiet retry on shortfall |
| cmd_hold_on_drop_in_burst | input | 1 | Drop becomes hold inside a burst |
| cmd_hold_on_drop_solo | input | 1 | Drop becomes hold outside a burst |
| cmd_requeue_as_hold | input | 1 | Requeue becomes hold |
| cmd_chain_next | input | 1 | Chain next command after success |
| cmd_chain_pifs | input | 1 | Chained space: 0 short, 1 point-coordination |
| att_valid | input | 1 | Attempt result strobe |
| att_success | input | 1 | Attempt succeeded |
| att_bw_short | input | 1 | Required bandwidth was not available |
| att_requeue | input | 1 | Requeue condition |
| act_valid | output | 1 | Action valid (one cycle) |
| act_code | output | 3 | Action code |
| try_count | output | CNT_W | Counted failed attempts of current command |
| chain_pifs | output | 1 | Interframe space choice for a chained start |

## Verification
The hardest situation to reach is the drop rule applied inside a burst. It needs a chained success on one command, then a fresh load whose shortfall or exhausted limit triggers a drop, with the solo stall bit set against the burst hold bit so that the two paths give different codes. The stimulus builds these pairs explicitly. It then runs a long random phase of loads and attempts, in which a behavioural model tracks burst state and counts across many command boundaries and is compared every clock.

// File: rtl/cmd_retry_pkg.sv
package cmd_retry_pkg;

    typedef enum logic [2:0] {
        ACT_DONE  = 3'd0,
        ACT_RETRY = 3'd1,
        ACT_DROP  = 3'd2,
        ACT_HOLD  = 3'd3,
        ACT_CHAIN = 3'd4
    } act_e;

    // Raw classification before the drop rule is resolved
    typedef enum logic [2:0] {
        RAW_DONE,
        RAW_CHAIN,
        RAW_RETRY,
        RAW_DROP_REQ,
        RAW_HOLD
    } raw_e;

    typedef struct packed {
        logic resp_exp;
        logic bw_chk;
        logic drop_on_bw;
        logic hold_in_burst;
        logic hold_solo;
        logic requeue_hold;
        logic chain;
        logic chain_pifs;
    } cmd_flags_t;

endpackage

// File: rtl/cmd_outcome_dec.sv
module cmd_outcome_dec
    import cmd_retry_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  cmd_flags_t       flags,
    input  logic [CNT_W-1:0] limit,
    input  logic [CNT_W-1:0] try_cnt,
    input  logic             success,
    input  logic             bw_short,
    input  logic             requeue,
    output raw_e             raw_kind,
    output logic             cnt_inc
);
    localparam int unsigned EXT_W = CNT_W + 1;

    logic [EXT_W-1:0] limit_eff;
    logic [EXT_W-1:0] next_cnt;

    always_comb begin
        limit_eff = (limit == '0) ? EXT_W'(1) : {1'b0, limit};
        next_cnt  = {1'b0, try_cnt} + EXT_W'(1);
        raw_kind  = RAW_DONE;
        cnt_inc   = 1'b0;
        if (bw_short && flags.bw_chk) begin
            raw_kind = flags.drop_on_bw ? RAW_DROP_REQ : RAW_RETRY;
        end else if (requeue) begin
            raw_kind = flags.requeue_hold ? RAW_HOLD : RAW_RETRY;
        end else if (success) begin
            raw_kind = flags.chain ? RAW_CHAIN : RAW_DONE;
        end else if (!flags.resp_exp) begin
            raw_kind = RAW_DONE;
        end else begin
            cnt_inc  = 1'b1;
            raw_kind = (next_cnt >= limit_eff) ? RAW_DROP_REQ : RAW_RETRY;
        end
    end
endmodule

// File: rtl/cmd_drop_resolve.sv
module cmd_drop_resolve
    import cmd_retry_pkg::*;
(
    input  raw_e raw_kind,
    input  logic in_burst,
    input  logic hold_in_burst,
    input  logic hold_solo,
    output act_e act
);
    logic hold_sel;

    always_comb begin
        hold_sel = in_burst ? hold_in_burst : hold_solo;
        unique case (raw_kind)
            RAW_DONE:     act = ACT_DONE;
            RAW_CHAIN:    act = ACT_CHAIN;
            RAW_RETRY:    act = ACT_RETRY;
            RAW_HOLD:     act = ACT_HOLD;
            RAW_DROP_REQ: act = hold_sel ? ACT_HOLD : ACT_DROP;
            default:      act = ACT_DONE;
        endcase
    end
endmodule

// File: rtl/txcmd_outcome_ctrl.sv
module txcmd_outcome_ctrl
    import cmd_retry_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_load,
    input  logic [CNT_W-1:0] cmd_retry_limit,
    input  logic             cmd_resp_expected,
    input  logic             cmd_bw_check_en,
    input  logic             cmd_drop_on_bw_short,
    input  logic             cmd_hold_on_drop_in_burst,
    input  logic             cmd_hold_on_drop_solo,
    input  logic             cmd_requeue_as_hold,
    input  logic             cmd_chain_next,
    input  logic             cmd_chain_pifs,
    input  logic             att_valid,
    input  logic             att_success,
    input  logic             att_bw_short,
    input  logic             att_requeue,
    output logic             act_valid,
    output logic [2:0]       act_code,
    output logic [CNT_W-1:0] try_count,
    output logic             chain_pifs
);
    localparam int unsigned EXT_W = CNT_W + 1;

    typedef struct packed {
        logic             active;
        logic             burst;
        logic [CNT_W-1:0] try_cnt;
        logic [CNT_W-1:0] limit;
        cmd_flags_t       flags;
        logic             act_valid;
        act_e             act_code;
        logic             pifs;
    } state_t;

    state_t st_d, st_q;
    raw_e   raw_kind;
    logic   cnt_inc;
    act_e   act_sel;

    cmd_outcome_dec #(.CNT_W(CNT_W)) i_dec (
        .flags    (st_q.flags),
        .limit    (st_q.limit),
        .try_cnt  (st_q.try_cnt),
        .success  (att_success),
        .bw_short (att_bw_short),
        .requeue  (att_requeue),
        .raw_kind (raw_kind),
        .cnt_inc  (cnt_inc)
    );

    cmd_drop_resolve i_res (
        .raw_kind      (raw_kind),
        .in_burst      (st_q.burst),
        .hold_in_burst (st_q.flags.hold_in_burst),
        .hold_solo     (st_q.flags.hold_solo),
        .act           (act_sel)
    );

    always_comb begin
        st_d           = st_q;
        st_d.act_valid = 1'b0;
        st_d.act_code  = ACT_DONE;
        st_d.pifs      = 1'b0;
        if (cmd_load) begin
            st_d.active  = 1'b1;
            st_d.try_cnt = '0;
            st_d.limit   = cmd_retry_limit;
            st_d.flags   = '{resp_exp:      cmd_resp_expected,
                             bw_chk:        cmd_bw_check_en,
                             drop_on_bw:    cmd_drop_on_bw_short,
                             hold_in_burst: cmd_hold_on_drop_in_burst,
                             hold_solo:     cmd_hold_on_drop_solo,
                             requeue_hold:  cmd_requeue_as_hold,
                             chain:         cmd_chain_next,
                             chain_pifs:    cmd_chain_pifs};
        end else if (att_valid && st_q.active) begin
            st_d.act_valid = 1'b1;
            st_d.act_code  = act_sel;
            st_d.pifs      = (act_sel == ACT_CHAIN) && st_q.flags.chain_pifs;
            st_d.burst     = (act_sel == ACT_CHAIN);
            st_d.active    = (act_sel == ACT_RETRY);
            if (cnt_inc) begin
                st_d.try_cnt = st_q.try_cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_valid  = st_q.act_valid;
    assign act_code   = st_q.act_code;
    assign try_count  = st_q.try_cnt;
    assign chain_pifs = st_q.pifs;

    // Assertions
    logic [EXT_W-1:0] lim_eff_chk;
    assign lim_eff_chk = (st_q.limit == '0) ? EXT_W'(1) : {1'b0, st_q.limit};

    assert_act_follows_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid |-> $past(att_valid) && !$past(cmd_load));

    assert_load_clears_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_load |=> (try_count == '0) && !act_valid);

    assert_idle_ignores_results_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.active && !cmd_load) |=> !act_valid);

    assert_pifs_only_on_chain_R4: assert property (@(posedge clk) disable iff (!rst_n)
        chain_pifs |-> act_valid && (act_code == 3'd4));

    assert_retry_below_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (act_valid && act_code == 3'd1) |-> ({1'b0, try_count} < lim_eff_chk));

    assert_code_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid |-> (act_code <= 3'd4));

endmodule

// File: tb/test_txcmd_outcome_ctrl.sv
module test_txcmd_outcome_ctrl;
    localparam int CW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_load = 0;
    logic [CW-1:0] cmd_retry_limit = '0;
    logic f_resp = 0, f_bwc = 0, f_dbw = 0, f_hib = 0, f_hso = 0, f_rqh = 0, f_ch = 0, f_pifs = 0;
    logic att_valid = 0, att_success = 0, att_bw_short = 0, att_requeue = 0;
    logic act_valid;
    logic [2:0] act_code;
    logic [CW-1:0] try_count;
    logic chain_pifs;

    int n_tests = 0, n_fail = 0;

    always #10 clk = ~clk;

    txcmd_outcome_ctrl #(.CNT_W(CW)) i_txcmd_outcome_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_load(cmd_load), .cmd_retry_limit(cmd_retry_limit),
        .cmd_resp_expected(f_resp), .cmd_bw_check_en(f_bwc), .cmd_drop_on_bw_short(f_dbw),
        .cmd_hold_on_drop_in_burst(f_hib), .cmd_hold_on_drop_solo(f_hso),
        .cmd_requeue_as_hold(f_rqh), .cmd_chain_next(f_ch), .cmd_chain_pifs(f_pifs),
        .att_valid(att_valid), .att_success(att_success), .att_bw_short(att_bw_short),
        .att_requeue(att_requeue), .act_valid(act_valid), .act_code(act_code),
        .try_count(try_count), .chain_pifs(chain_pifs)
    );

    // Behavioural reference model
    int m_active = 0, m_burst = 0, m_try = 0, m_lim = 0;
    bit m_resp, m_bwc, m_dbw, m_hib, m_hso, m_rqh, m_ch, m_pifs_cfg;
    int m_av = 0, m_code = 0, m_pifs = 0;

    function automatic int drop_rule();
        if (m_burst != 0) return m_hib ? 3 : 2;
        return m_hso ? 3 : 2;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = 0; m_burst = 0; m_try = 0; m_av = 0; m_code = 0; m_pifs = 0;
        end else begin
            int c;
            m_av = 0; m_code = 0; m_pifs = 0;
            if (cmd_load) begin
                m_active = 1; m_try = 0; m_lim = int'(cmd_retry_limit);
                m_resp = f_resp; m_bwc = f_bwc; m_dbw = f_dbw; m_hib = f_hib;
                m_hso = f_hso; m_rqh = f_rqh; m_ch = f_ch; m_pifs_cfg = f_pifs;
            end else if (att_valid && m_active != 0) begin
                if (att_bw_short && m_bwc) c = m_dbw ? drop_rule() : 1;
                else if (att_requeue) c = m_rqh ? 3 : 1;
                else if (att_success) c = m_ch ? 4 : 0;
                else if (!m_resp) c = 0;
                else begin
                    m_try++;
                    c = (m_try >= ((m_lim == 0) ? 1 : m_lim)) ? drop_rule() : 1;
                end
                m_av = 1; m_code = c;
                m_pifs = (c == 4 && m_pifs_cfg) ? 1 : 0;
                m_burst = (c == 4) ? 1 : 0;
                if (c != 1) m_active = 0;
            end
        end
    end

    string cur_req = "R1";

    always @(negedge clk) begin
        if (rst_n) begin
            n_tests++;
            if (int'(act_valid) != m_av || (m_av != 0 && int'(act_code) != m_code) ||
                int'(try_count) != m_try || int'(chain_pifs) != m_pifs) begin
                n_fail++;
                $display("FAIL %s model: act=%0d code=%0d try=%0d pifs=%0d expected act=%0d code=%0d try=%0d pifs=%0d",
                         cur_req, act_valid, act_code, try_count, chain_pifs, m_av, m_code, m_try, m_pifs);
            end
        end
    end

    task automatic chk(input string req, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic load(input int lim, input bit resp, input bit bwc, input bit dbw,
                        input bit hib, input bit hso, input bit rqh, input bit ch, input bit pf);
        @(negedge clk);
        cmd_load = 1; cmd_retry_limit = CW'(lim);
        f_resp = resp; f_bwc = bwc; f_dbw = dbw; f_hib = hib; f_hso = hso;
        f_rqh = rqh; f_ch = ch; f_pifs = pf;
        @(negedge clk);
        cmd_load = 0;
    endtask

    // exp_code < 0 means no action expected
    task automatic attempt(input string req, input bit s, input bit bw, input bit rq,
                           input int exp_code, input int exp_try);
        @(negedge clk);
        att_valid = 1; att_success = s; att_bw_short = bw; att_requeue = rq;
        @(negedge clk);
        att_valid = 0; att_success = 0; att_bw_short = 0; att_requeue = 0;
        if (exp_code < 0) begin
            chk(req, int'(act_valid), 0);
        end else begin
            chk(req, int'(act_valid), 1);
            chk(req, int'(act_code), exp_code);
            chk(req, int'(try_count), exp_try);
        end
        @(negedge clk);
        chk({req, "/R3 one-cycle"}, int'(act_valid), 0);
    endtask

    initial begin : watchdog
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        cur_req = "R1";
        chk("R1 act_valid", int'(act_valid), 0);
        chk("R1 try_count", int'(try_count), 0);
        chk("R1 chain_pifs", int'(chain_pifs), 0);

        cur_req = "R2";
        attempt("R2 no active cmd", 0, 0, 0, -1, 0);

        cur_req = "R5";
        load(3, 1, 0, 0, 0, 0, 0, 0, 0);
        attempt("R5 fail 1", 0, 0, 0, 1, 1);
        attempt("R5 fail 2", 0, 0, 0, 1, 2);
        attempt("R5/R10 fail at limit drops", 0, 0, 0, 2, 3);
        cur_req = "R13";
        attempt("R13 after drop ignored", 0, 0, 0, -1, 3);

        cur_req = "R5";
        load(0, 1, 0, 0, 0, 0, 0, 0, 0);
        attempt("R5 limit 0 single try", 0, 0, 0, 2, 1);

        cur_req = "R10";
        load(1, 1, 0, 0, 1, 1, 0, 0, 0);
        attempt("R10 solo stall holds", 0, 0, 0, 3, 1);

        cur_req = "R6";
        load(1, 0, 0, 0, 0, 0, 0, 0, 0);
        attempt("R6 no response expected", 0, 0, 0, 0, 0);

        cur_req = "R7";
        load(2, 1, 1, 0, 0, 0, 0, 1, 1);
        attempt("R7 quiet retry", 0, 1, 0, 1, 0);
        cur_req = "R4";
        attempt("R4 chain pifs", 1, 0, 0, 4, 0);

        cur_req = "R9";
        load(2, 1, 1, 1, 1, 0, 0, 0, 0);
        attempt("R8/R9 burst hold on shortfall drop", 0, 1, 0, 3, 0);

        cur_req = "R4";
        load(2, 1, 0, 0, 0, 0, 0, 1, 0);
        @(negedge clk); att_valid = 1; att_success = 1;
        @(negedge clk); att_valid = 0; att_success = 0;
        chk("R4 chain code", int'(act_code), 4);
        chk("R4 chain short space", int'(chain_pifs), 0);
        cur_req = "R9";
        load(2, 1, 1, 1, 0, 1, 0, 0, 0);
        attempt("R9 burst ignores solo stall", 0, 1, 0, 2, 0);

        cur_req = "R12";
        load(2, 1, 0, 1, 0, 0, 0, 0, 0);
        attempt("R12 shortfall ignored when check off", 1, 1, 0, 0, 0);

        cur_req = "R11";
        load(2, 1, 0, 0, 0, 0, 1, 0, 0);
        attempt("R11 requeue as hold", 1, 0, 1, 3, 0);
        load(2, 1, 0, 0, 0, 0, 0, 0, 0);
        attempt("R11 requeue retry", 0, 0, 1, 1, 0);

        cur_req = "R2";
        load(3, 1, 0, 0, 0, 0, 0, 0, 0);
        attempt("R2 count before reload", 0, 0, 0, 1, 1);
        load(3, 1, 0, 0, 0, 0, 0, 0, 0);
        chk("R2 reload clears count", int'(try_count), 0);

        cur_req = "R4";
        attempt("R4 plain success", 1, 0, 0, 0, 0);

        cur_req = "R3 random";
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            cmd_load = ($urandom % 5) == 0;
            cmd_retry_limit = CW'($urandom % 5);
            {f_resp, f_bwc, f_dbw, f_hib, f_hso, f_rqh, f_ch, f_pifs} = 8'($urandom);
            att_valid = ($urandom % 2) == 0;
            att_success = ($urandom % 3) == 0;
            att_bw_short = ($urandom % 4) == 0;
            att_requeue = ($urandom % 6) == 0;
        end
        @(negedge clk);
        cmd_load = 0; att_valid = 0;
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule